// File: doc/BRIEF.md
# Four-Bit Accumulator Arithmetic Datapath

This block is a small synchronous arithmetic unit built around a 4-bit accumulator and two addressable 4-bit working registers, called A and B. An outside agent issues one command per clock cycle through a command port. The port carries a 3-bit operation code, a one-bit register select, a 4-bit data word and a valid strobe. The five commands are load, copy, add, subtract and clear. Add and subtract run through an internal ripple-carry adder-subtractor. That adder-subtractor reports signed (two's-complement) overflow, which is held in a flag.

The accumulator, both registers and the overflow flag are driven straight from flip-flops. A command that is accepted on a rising edge therefore shows its result on the outputs from that edge on. The block holds no program and does no sequencing. Whatever drives the command port decides what runs next.

Top module: `acc_alu4`

## Requirements
- R1: A synchronous active-high reset zeroes A, B, the accumulator and the overflow flag. It wins over any command presented in the same cycle.
- R2: Code 000 (load) writes the data word into the selected register. Select 0 means A and select 1 means B. The other register and the accumulator are left unchanged.
- R3: Code 001 (copy) writes the accumulator into the selected register. The accumulator itself is left unchanged.
- R4: Code 010 (add) sets the accumulator to the selected register plus the accumulator, modulo 16. The overflow flag is set when the signed sum falls outside -8..7 and cleared otherwise.
- R5: Code 011 (subtract) sets the accumulator to the accumulator minus the selected register, in that operand order only, modulo 16. The overflow flag is set when the signed difference falls outside -8..7 and cleared otherwise.
- R6: Code 100 (clear) sets the accumulator to zero.
- R7: Load, copy and clear leave the overflow flag unchanged.
- R8: When the valid strobe is low, or when the code is 101, 110 or 111, no register, accumulator or flag changes.
- R9: A command takes effect on the rising edge at which the valid strobe is high. The outputs keep their old values before that edge and show the new state after it.
- R10: Commands ignore the inputs they do not use. Add, subtract and copy ignore the data word. Clear ignores both the data word and the register select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 3 | Operation code |
| cmdAddr | input | 1 | Register select: 0 = A, 1 = B |
| cmdData | input | 4 | Word written by load |
| accOut | output | 4 | Accumulator |
| regAOut | output | 4 | Register A |
| regBOut | output | 4 | Register B |
| ovfOut | output | 1 | Signed overflow flag |

## Verification
The bound checker tests the following on every cycle, taken from the port values of the previous cycle:
- the reset state;
- the load targets;
- the add and subtract results, including the operand order of subtract;
- the clear;
- the holding of the flag across non-arithmetic commands;
- the freezing of all state on idle cycles and on unused codes.

The overflow value itself depends on signed range cases that only directed scenarios reach. Those cases are positive plus positive, negative plus negative, and subtracting -8 from a positive number. The directed scenarios also cover the other behaviours that need a chosen command order: reset winning over a command, unused select and data inputs having no effect, and the old value staying visible before the edge.

// File: rtl/acc_alu4_pkg.sv
package acc_alu4_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD  = 3'b000,
    OP_COPY  = 3'b001,
    OP_ADD   = 3'b010,
    OP_SUB   = 3'b011,
    OP_CLEAR = 3'b100
  } op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrReg;    // write the selected register
    logic fromAcc;  // register write source is the accumulator
    logic wrAcc;    // write the accumulator
    logic clrAcc;   // accumulator write value is zero
    logic subMode;  // adder-subtractor mode
    logic wrOvf;    // update overflow flag
    logic regSel;   // selected register
  } ctrl_t;

endpackage

// File: rtl/acc_alu4_ctrl.sv
module acc_alu4_ctrl
  import acc_alu4_pkg::*;
(
  input  logic            cmdValid,
  input  logic [OP_W-1:0] cmdOp,
  input  logic            cmdAddr,
  output ctrl_t           strobes
);

  always_comb begin
    strobes = '0;
    strobes.regSel = cmdAddr;
    if (cmdValid) begin
      case (cmdOp)
        OP_LOAD: strobes.wrReg = 1'b1;
        OP_COPY: begin
          strobes.wrReg   = 1'b1;
          strobes.fromAcc = 1'b1;
        end
        OP_ADD: begin
          strobes.wrAcc = 1'b1;
          strobes.wrOvf = 1'b1;
        end
        OP_SUB: begin
          strobes.wrAcc   = 1'b1;
          strobes.wrOvf   = 1'b1;
          strobes.subMode = 1'b1;
        end
        OP_CLEAR: begin
          strobes.wrAcc  = 1'b1;
          strobes.clrAcc = 1'b1;
        end
        default: strobes = '0;
      endcase
    end
  end

endmodule

// File: rtl/acc_alu4_addsub.sv
module acc_alu4_addsub #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             subMode,
  output logic [WIDTH-1:0] result,
  output logic             signedOvf
);

  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] bEff;

  assign carry[0] = subMode;

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_stage
    assign bEff[gi]      = opB[gi] ^ subMode;
    assign result[gi]    = opA[gi] ^ bEff[gi] ^ carry[gi];
    assign carry[gi+1]   = (opA[gi] & bEff[gi]) | (carry[gi] & (opA[gi] ^ bEff[gi]));
  end

  // carry into top stage differs from carry out of it
  assign signedOvf = carry[WIDTH] ^ carry[WIDTH-1];

endmodule

// File: rtl/acc_alu4_datapath.sv
module acc_alu4_datapath
  import acc_alu4_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            strobes,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] accQ,
  output logic [WIDTH-1:0] regAQ,
  output logic [WIDTH-1:0] regBQ,
  output logic             ovfQ
);

  localparam int REG_CNT = 2;

  logic [WIDTH-1:0] regFile [REG_CNT];
  logic [WIDTH-1:0] selReg;
  logic [WIDTH-1:0] regWrVal;
  logic [WIDTH-1:0] accWrVal;
  logic [WIDTH-1:0] aluA;
  logic [WIDTH-1:0] aluB;
  logic [WIDTH-1:0] aluRes;
  logic             aluOvf;

  assign selReg   = regFile[strobes.regSel];
  assign regWrVal = strobes.fromAcc ? accQ : dataIn;

  // subtract: acc - reg; add: reg + acc
  assign aluA = strobes.subMode ? accQ   : selReg;
  assign aluB = strobes.subMode ? selReg : accQ;

  acc_alu4_addsub #(.WIDTH(WIDTH)) u_addsub (
    .opA      (aluA),
    .opB      (aluB),
    .subMode  (strobes.subMode),
    .result   (aluRes),
    .signedOvf(aluOvf)
  );

  assign accWrVal = strobes.clrAcc ? '0 : aluRes;

  for (genvar gr = 0; gr < REG_CNT; gr++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regFile[gr] <= '0;
      end else if (strobes.wrReg && (int'(strobes.regSel) == gr)) begin
        regFile[gr] <= regWrVal;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accQ <= '0;
      ovfQ <= 1'b0;
    end else begin
      if (strobes.wrAcc) accQ <= accWrVal;
      if (strobes.wrOvf) ovfQ <= aluOvf;
    end
  end

  assign regAQ = regFile[0];
  assign regBQ = regFile[1];

endmodule

// File: rtl/acc_alu4.sv
module acc_alu4
  import acc_alu4_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic             cmdAddr,
  input  logic [WIDTH-1:0] cmdData,
  output logic [WIDTH-1:0] accOut,
  output logic [WIDTH-1:0] regAOut,
  output logic [WIDTH-1:0] regBOut,
  output logic             ovfOut
);

  ctrl_t strobes;

  acc_alu4_ctrl u_ctrl (
    .cmdValid(cmdValid),
    .cmdOp   (cmdOp),
    .cmdAddr (cmdAddr),
    .strobes (strobes)
  );

  acc_alu4_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .dataIn (cmdData),
    .accQ   (accOut),
    .regAQ  (regAOut),
    .regBQ  (regBOut),
    .ovfQ   (ovfOut)
  );

endmodule

// File: rtl/acc_alu4_checker.sv
module acc_alu4_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cmdValid,
  input logic [2:0]       cmdOp,
  input logic             cmdAddr,
  input logic [WIDTH-1:0] cmdData,
  input logic [WIDTH-1:0] accOut,
  input logic [WIDTH-1:0] regAOut,
  input logic [WIDTH-1:0] regBOut,
  input logic             ovfOut
);

  logic [WIDTH-1:0] selReg;
  assign selReg = cmdAddr ? regBOut : regAOut;

  // R1: the cycle after reset, all state is zero
  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (accOut == '0 && regAOut == '0 && regBOut == '0 && !ovfOut));

  // R2: load writes the data word into the selected register
  p_load_target_r2: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdOp == 3'b000) |=>
      ((($past(cmdAddr) ? regBOut : regAOut) == $past(cmdData)) && $stable(accOut)));

  // R4: add result
  p_add_result_r4: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdOp == 3'b010) |=>
      (accOut == WIDTH'($past(selReg) + $past(accOut))));

  // R5: subtract result, fixed order
  p_sub_order_r5: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdOp == 3'b011) |=>
      (accOut == WIDTH'($past(accOut) - $past(selReg))));

  // R6: clear zeroes the accumulator
  p_clear_acc_r6: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdOp == 3'b100) |=> (accOut == '0));

  // R7: non-arithmetic commands hold the flag
  p_ovf_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && (cmdOp == 3'b000 || cmdOp == 3'b001 || cmdOp == 3'b100)) |=> $stable(ovfOut));

  // R8: idle cycles and unused codes freeze all state
  p_idle_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (!cmdValid || cmdOp > 3'b100) |=>
      ($stable(accOut) && $stable(regAOut) && $stable(regBOut) && $stable(ovfOut)));

endmodule

bind acc_alu4 acc_alu4_checker #(.WIDTH(WIDTH)) u_acc_alu4_checker (
  .clk     (clk),
  .rst     (rst),
  .cmdValid(cmdValid),
  .cmdOp   (cmdOp),
  .cmdAddr (cmdAddr),
  .cmdData (cmdData),
  .accOut  (accOut),
  .regAOut (regAOut),
  .regBOut (regBOut),
  .ovfOut  (ovfOut)
);

// File: tb/test_acc_alu4.sv
module test_acc_alu4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmdValid = 1'b0;
  logic [2:0] cmdOp = 3'b000;
  logic       cmdAddr = 1'b0;
  logic [3:0] cmdData = 4'h0;
  logic [3:0] accOut, regAOut, regBOut;
  logic       ovfOut;

  int nChecks = 0;
  int nFails  = 0;

  // bench model
  logic [3:0] mA = 4'h0, mB = 4'h0, mAcc = 4'h0;
  logic       mOvf = 1'b0;

  always #10 clk = ~clk;

  acc_alu4 i_acc_alu4 (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .accOut(accOut),
    .regAOut(regAOut), .regBOut(regBOut), .ovfOut(ovfOut)
  );

  task automatic check(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    check(req, "acc", accOut, mAcc);
    check(req, "regA", regAOut, mA);
    check(req, "regB", regBOut, mB);
    check(req, "ovf", {3'b0, ovfOut}, {3'b0, mOvf});
  endtask

  // drive at negedge, update model, let the edge pass, back at negedge
  task automatic doCmd(input logic v, input logic [2:0] op, input logic ad, input logic [3:0] d);
    int s;
    logic [3:0] sel;
    cmdValid = v; cmdOp = op; cmdAddr = ad; cmdData = d;
    sel = ad ? mB : mA;
    if (v) begin
      case (op)
        3'b000: if (ad) mB = d; else mA = d;
        3'b001: if (ad) mB = mAcc; else mA = mAcc;
        3'b010: begin
          s = int'($signed(sel)) + int'($signed(mAcc));
          mOvf = (s < -8) || (s > 7);
          mAcc = 4'(s);
        end
        3'b011: begin
          s = int'($signed(mAcc)) - int'($signed(sel));
          mOvf = (s < -8) || (s > 7);
          mAcc = 4'(s);
        end
        3'b100: mAcc = 4'h0;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic applyReset();
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    mA = 0; mB = 0; mAcc = 0; mOvf = 0;
  endtask

  task automatic testResetState();
    applyReset();
    checkAll("R1");
  endtask

  task automatic testWorkedSequence();
    doCmd(1, 3'b000, 0, 4'd4); checkAll("R2");
    doCmd(1, 3'b000, 1, 4'd2); checkAll("R2");
    doCmd(1, 3'b010, 0, 4'hF); checkAll("R4");
    doCmd(1, 3'b010, 1, 4'h9); check("R4", "acc 0110", accOut, 4'b0110);
    doCmd(1, 3'b000, 0, 4'd7);
    doCmd(1, 3'b011, 0, 4'h3); check("R5", "acc -1", accOut, 4'b1111);
    check("R5", "ovf", {3'b0, ovfOut}, 4'h0);
  endtask

  task automatic testAddOverflow();
    doCmd(1, 3'b100, 0, 0);
    doCmd(1, 3'b000, 0, 4'b1010);
    doCmd(1, 3'b010, 0, 0);
    doCmd(1, 3'b000, 1, 4'b1000);
    doCmd(1, 3'b010, 1, 0);
    check("R4", "10+8 sum", accOut, 4'b0010);
    check("R4", "10+8 ovf", {3'b0, ovfOut}, 4'h1);
    doCmd(1, 3'b100, 0, 0);
    doCmd(1, 3'b000, 0, 4'd5);
    doCmd(1, 3'b010, 0, 0);
    doCmd(1, 3'b010, 0, 0); checkAll("R4 pos+pos");
  endtask

  task automatic testSubOrder();
    doCmd(1, 3'b100, 0, 0);
    doCmd(1, 3'b000, 0, 4'd3);
    doCmd(1, 3'b010, 0, 0);
    doCmd(1, 3'b000, 1, 4'd5);
    doCmd(1, 3'b011, 1, 4'hA);
    check("R5", "3-5", accOut, 4'b1110);
    checkAll("R5");
    doCmd(1, 3'b100, 0, 0);
    doCmd(1, 3'b000, 0, 4'd7);
    doCmd(1, 3'b010, 0, 0);
    doCmd(1, 3'b000, 1, 4'b1000);
    doCmd(1, 3'b011, 1, 0);
    check("R5", "7-(-8) ovf", {3'b0, ovfOut}, 4'h1);
    checkAll("R5");
  endtask

  task automatic testCopyClearHold();
    // flag is 1 here
    doCmd(1, 3'b001, 0, 4'h0); checkAll("R3 copy to A");
    check("R7", "ovf after copy", {3'b0, ovfOut}, 4'h1);
    doCmd(1, 3'b000, 1, 4'd1); checkAll("R7 after load");
    doCmd(1, 3'b100, 1, 4'hF); checkAll("R6 clear");
    check("R10", "regB after clear with data", regBOut, 4'd1);
    check("R7", "ovf after clear", {3'b0, ovfOut}, 4'h1);
    doCmd(1, 3'b010, 1, 4'hE); checkAll("R4 clears ovf");
    doCmd(1, 3'b001, 1, 4'h5); checkAll("R10 copy ignores data");
  endtask

  task automatic testIdle();
    doCmd(1, 3'b000, 0, 4'd6);
    doCmd(0, 3'b000, 1, 4'hC); checkAll("R8 valid low");
    doCmd(1, 3'b101, 0, 4'hC); checkAll("R8 code 101");
    doCmd(1, 3'b110, 1, 4'hC); checkAll("R8 code 110");
    doCmd(1, 3'b111, 0, 4'hC); checkAll("R8 code 111");
  endtask

  task automatic testTiming();
    cmdValid = 1; cmdOp = 3'b000; cmdAddr = 1; cmdData = 4'h9;
    #1;
    check("R9", "regB before edge", regBOut, mB);
    @(posedge clk); @(negedge clk);
    cmdValid = 0;
    mB = 4'h9;
    check("R9", "regB after edge", regBOut, 4'h9);
  endtask

  task automatic testResetPriority();
    rst = 1'b1;
    cmdValid = 1; cmdOp = 3'b000; cmdAddr = 0; cmdData = 4'hD;
    @(posedge clk); @(negedge clk);
    rst = 1'b0; cmdValid = 0;
    mA = 0; mB = 0; mAcc = 0; mOvf = 0;
    checkAll("R1 priority");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    @(negedge clk);
    testResetState();
    testWorkedSequence();
    testAddOverflow();
    testSubOrder();
    testCopyClearHold();
    testIdle();
    testTiming();
    testResetPriority();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule